// File: doc/BRIEF.md
# Configurable Pin Cell with Selectable Capture and Drive Enable

This block is one pin's worth of I/O logic for a programmable logic device. A static mode field set by configuration turns the pin into one of five kinds: a plain combinatorial input, an input sampled by a flip-flop, an input held by a level-sensitive latch, an output-only pin, or a bidirectional pin whose driver is switched by an enable signal. The pad itself is modelled as three plain signals: the level seen at the pin, the value to drive, and the driver enable.

In bidirectional mode the driver enable comes from one of two sources, picked by configuration. One is a single global enable shared by the whole device. The other is a bank of product-term enables, one from each logic group, and every cell can see all of them. A select field picks one of those lines. The capture flip-flop and the latch take their clock from one of the dedicated I/O clocks. A select field picks that clock.

The cell holds no state apart from the capture element. The configuration is meant to stay fixed while the pin is in use.

Top module: `pio_cell`

## Requirements
- R1: For mode code 0 (combinatorial input), and for the unused codes 5, 6 and 7, `core_in` follows `pad_in` with no clock involved and `pad_oe` is 0.
- R2: For mode code 1 (registered input), `core_in` takes the value `pad_in` had at a rising edge of the selected I/O clock. It holds that value until the next rising edge.
- R3: For mode code 2 (latched input), `core_in` follows `pad_in` while the selected I/O clock is high. It keeps the last value while that clock is low.
- R4: `cfg_clk_sel` picks bit `cfg_clk_sel` of `io_clk` as the clock for capture. Edges on any other I/O clock do not change `core_in`.
- R5: In every input-only mode (codes 0, 1, 2, 5, 6, 7), `pad_oe` is 0 and `pad_out` is 0.
- R6: For mode code 3 (output only), `pad_oe` is 1, `pad_out` equals `core_out`, and `core_in` is 0.
- R7: For mode code 4 (bidirectional), `pad_out` equals `core_out` and `core_in` follows `pad_in` combinationally. `pad_oe` equals `glob_oe` when `cfg_oe_src` is 0, and equals the selected product-term enable when `cfg_oe_src` is 1.
- R8: The selected product-term enable is bit `cfg_pt_sel` of `pt_oe`, where bit i comes from logic group i.
- R9: `rst` is active high and synchronous to the selected clock. If `rst` is high at a rising edge, the capture register clears to 0. If `rst` is high while the selected clock is high, the latch output clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | NUM_IOCLK | Dedicated I/O clocks |
| rst | input | 1 | Synchronous reset for the capture element, active high |
| cfg_mode | input | 3 | Pin mode code |
| cfg_oe_src | input | 1 | Enable source select: 0 = global enable, 1 = product-term enable |
| cfg_pt_sel | input | PT_SEL_W | Index of the product-term enable line |
| cfg_clk_sel | input | CLK_SEL_W | Index of the capture clock |
| glob_oe | input | 1 | Global output enable |
| pt_oe | input | NUM_PTOE | Product-term enables, one per logic group |
| core_out | input | 1 | Data from the core to drive onto the pin |
| core_in | output | 1 | Pin data delivered to the core |
| pad_in | input | 1 | Level seen at the pin |
| pad_out | output | 1 | Value driven onto the pin |
| pad_oe | output | 1 | Pin driver enable |

## Verification
The bench uses the default parameters: eight product-term enable lines and two I/O clocks. With these values every enable select code from 0 to 7 is a valid line, so random selects cover the whole index range. The first I/O clock runs freely. The second is pulsed by hand, which allows a check that edges on the clock that is not selected leave the captured value unchanged. All eight mode codes are drawn at random, including the three unused ones. Directed sequences cover the latch changing during the high phase, the latch holding through the low phase, and reset of both capture elements.

// File: rtl/pio_cell_pkg.sv
package pio_cell_pkg;

    // Mode codes carried on cfg_mode
    localparam logic [2:0] MODE_COMB  = 3'd0;
    localparam logic [2:0] MODE_REG   = 3'd1;
    localparam logic [2:0] MODE_LATCH = 3'd2;
    localparam logic [2:0] MODE_OUT   = 3'd3;
    localparam logic [2:0] MODE_BIDIR = 3'd4;

    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,
        DRV_ON     = 2'd1,
        DRV_FOLLOW = 2'd2
    } drive_e;

    typedef enum logic [1:0] {
        IN_COMB  = 2'd0,
        IN_REG   = 2'd1,
        IN_LATCH = 2'd2,
        IN_ZERO  = 2'd3
    } insrc_e;

    typedef struct packed {
        drive_e drive;
        insrc_e insrc;
    } cell_ctrl_t;

endpackage

// File: rtl/pio_mode_decode.sv
module pio_mode_decode
    import pio_cell_pkg::*;
(
    input  logic [2:0] mode_raw,
    output cell_ctrl_t ctrl
);

    always_comb begin
        unique case (mode_raw)
            MODE_REG:   ctrl = '{drive: DRV_OFF,    insrc: IN_REG};
            MODE_LATCH: ctrl = '{drive: DRV_OFF,    insrc: IN_LATCH};
            MODE_OUT:   ctrl = '{drive: DRV_ON,     insrc: IN_ZERO};
            MODE_BIDIR: ctrl = '{drive: DRV_FOLLOW, insrc: IN_COMB};
            // code 0 and the unused codes: plain input, driver off
            default:    ctrl = '{drive: DRV_OFF,    insrc: IN_COMB};
        endcase
    end

endmodule

// File: rtl/pio_oe_select.sv
module pio_oe_select
    import pio_cell_pkg::*;
#(
    parameter int NUM_PTOE = 8,
    localparam int PT_SEL_W = (NUM_PTOE > 1) ? $clog2(NUM_PTOE) : 1
) (
    input  drive_e                drive,
    input  logic                  oe_src,
    input  logic [PT_SEL_W-1:0]   pt_sel,
    input  logic                  glob_oe,
    input  logic [NUM_PTOE-1:0]   pt_oe,
    input  logic                  core_out,
    output logic                  pad_oe,
    output logic                  pad_out
);

    logic pt_pick;
    logic follow_oe;

    // An out-of-range index selects an inactive line
    always_comb begin
        pt_pick = 1'b0;
        for (int i = 0; i < NUM_PTOE; i++) begin
            if (int'(pt_sel) == i) pt_pick = pt_oe[i];
        end
    end

    assign follow_oe = oe_src ? pt_pick : glob_oe;

    always_comb begin
        unique case (drive)
            DRV_ON:     pad_oe = 1'b1;
            DRV_FOLLOW: pad_oe = follow_oe;
            default:    pad_oe = 1'b0;
        endcase
        pad_out = (drive == DRV_OFF) ? 1'b0 : core_out;
    end

endmodule

// File: rtl/pio_capture.sv
module pio_capture
    import pio_cell_pkg::*;
#(
    parameter int NUM_IOCLK = 2,
    localparam int CLK_SEL_W = (NUM_IOCLK > 1) ? $clog2(NUM_IOCLK) : 1
) (
    input  logic [NUM_IOCLK-1:0]  io_clk,
    input  logic [CLK_SEL_W-1:0]  clk_sel,
    input  logic                  rst,
    input  insrc_e                insrc,
    input  logic                  pad_in,
    output logic                  cap_clk,
    output logic                  core_in
);

    logic reg_q;
    logic lat_q;

    always_comb begin
        cap_clk = 1'b0;
        for (int i = 0; i < NUM_IOCLK; i++) begin
            if (int'(clk_sel) == i) cap_clk = io_clk[i];
        end
    end

    always_ff @(posedge cap_clk) begin
        if (rst) reg_q <= 1'b0;
        else     reg_q <= pad_in;
    end

    always_latch begin
        if (cap_clk) lat_q = rst ? 1'b0 : pad_in;
    end

    always_comb begin
        unique case (insrc)
            IN_REG:   core_in = reg_q;
            IN_LATCH: core_in = lat_q;
            IN_ZERO:  core_in = 1'b0;
            default:  core_in = pad_in;
        endcase
    end

endmodule

// File: rtl/pio_cell.sv
module pio_cell
    import pio_cell_pkg::*;
#(
    parameter int NUM_PTOE  = 8,
    parameter int NUM_IOCLK = 2,
    localparam int PT_SEL_W  = (NUM_PTOE > 1) ? $clog2(NUM_PTOE) : 1,
    localparam int CLK_SEL_W = (NUM_IOCLK > 1) ? $clog2(NUM_IOCLK) : 1
) (
    input  logic [NUM_IOCLK-1:0] io_clk,
    input  logic                 rst,
    input  logic [2:0]           cfg_mode,
    input  logic                 cfg_oe_src,
    input  logic [PT_SEL_W-1:0]  cfg_pt_sel,
    input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input  logic                 glob_oe,
    input  logic [NUM_PTOE-1:0]  pt_oe,
    input  logic                 core_out,
    output logic                 core_in,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe
);

    cell_ctrl_t ctrl;
    logic       cap_clk;

    pio_mode_decode u_decode (
        .mode_raw (cfg_mode),
        .ctrl     (ctrl)
    );

    pio_oe_select #(.NUM_PTOE(NUM_PTOE)) u_oe (
        .drive    (ctrl.drive),
        .oe_src   (cfg_oe_src),
        .pt_sel   (cfg_pt_sel),
        .glob_oe  (glob_oe),
        .pt_oe    (pt_oe),
        .core_out (core_out),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    pio_capture #(.NUM_IOCLK(NUM_IOCLK)) u_cap (
        .io_clk   (io_clk),
        .clk_sel  (cfg_clk_sel),
        .rst      (rst),
        .insrc    (ctrl.insrc),
        .pad_in   (pad_in),
        .cap_clk  (cap_clk),
        .core_in  (core_in)
    );

endmodule

// File: rtl/pio_cell_checker.sv
module pio_cell_checker #(
    parameter int NUM_PTOE = 8,
    localparam int PT_SEL_W = (NUM_PTOE > 1) ? $clog2(NUM_PTOE) : 1
) (
    input logic                cap_clk,
    input logic                rst,
    input logic [2:0]          cfg_mode,
    input logic                cfg_oe_src,
    input logic [PT_SEL_W-1:0] cfg_pt_sel,
    input logic                glob_oe,
    input logic [NUM_PTOE-1:0] pt_oe,
    input logic                core_out,
    input logic                core_in,
    input logic                pad_in,
    input logic                pad_out,
    input logic                pad_oe
);

    logic in_only;
    assign in_only = (cfg_mode != 3'd3) && (cfg_mode != 3'd4);

    // R1: combinatorial and unused codes pass the pin straight through
    p_comb_pass_r1: assert property (@(posedge cap_clk) disable iff (rst)
        (in_only && cfg_mode != 3'd1 && cfg_mode != 3'd2) |-> (core_in == pad_in));

    // R2: registered mode presents the level sampled at the previous edge
    p_reg_capture_r2: assert property (@(posedge cap_clk) disable iff (rst)
        (cfg_mode == 3'd1) |=> (cfg_mode != 3'd1 || core_in == $past(pad_in)));

    // R5: input-only modes never drive the pin
    p_in_driver_off_r5: assert property (@(posedge cap_clk) disable iff (rst)
        in_only |-> (!pad_oe && !pad_out));

    // R6: output mode drives core data with the driver on
    p_out_drive_r6: assert property (@(posedge cap_clk) disable iff (rst)
        (cfg_mode == 3'd3) |-> (pad_oe && pad_out == core_out && !core_in));

    // R7: bidirectional mode drives core data and follows the chosen enable
    p_bidir_r7: assert property (@(posedge cap_clk) disable iff (rst)
        (cfg_mode == 3'd4 && !cfg_oe_src) |-> (pad_oe == glob_oe && pad_out == core_out));

    // R8: product-term source picks the indexed line
    p_pt_pick_r8: assert property (@(posedge cap_clk) disable iff (rst)
        (cfg_mode == 3'd4 && cfg_oe_src) |-> (pad_oe == pt_oe[cfg_pt_sel]));

    // R9: reset at an edge clears the capture register
    p_reset_reg_r9: assert property (@(posedge cap_clk)
        (rst && cfg_mode == 3'd1) |=> (cfg_mode != 3'd1 || !core_in));

endmodule

bind pio_cell pio_cell_checker #(.NUM_PTOE(NUM_PTOE)) u_chk (
    .cap_clk    (cap_clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .cfg_oe_src (cfg_oe_src),
    .cfg_pt_sel (cfg_pt_sel),
    .glob_oe    (glob_oe),
    .pt_oe      (pt_oe),
    .core_out   (core_out),
    .core_in    (core_in),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/pio_cell_bench.sv
`timescale 1ns/1ps
module pio_cell_bench;

    localparam int NUM_PTOE  = 8;
    localparam int NUM_IOCLK = 2;

    logic       clk0 = 1'b0;
    logic       clk1 = 1'b0;
    logic       rst;
    logic [2:0] cfg_mode;
    logic       cfg_oe_src;
    logic [2:0] cfg_pt_sel;
    logic       cfg_clk_sel;
    logic       glob_oe;
    logic [7:0] pt_oe;
    logic       core_out;
    logic       core_in;
    logic       pad_in;
    logic       pad_out;
    logic       pad_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk0 = ~clk0;

    pio_cell #(.NUM_PTOE(NUM_PTOE), .NUM_IOCLK(NUM_IOCLK)) u_pio_cell (
        .io_clk      ({clk1, clk0}),
        .rst         (rst),
        .cfg_mode    (cfg_mode),
        .cfg_oe_src  (cfg_oe_src),
        .cfg_pt_sel  (cfg_pt_sel),
        .cfg_clk_sel (cfg_clk_sel),
        .glob_oe     (glob_oe),
        .pt_oe       (pt_oe),
        .core_out    (core_out),
        .core_in     (core_in),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe)
    );

    function automatic logic exp_oe(logic [2:0] m, logic src, logic [2:0] sel,
                                    logic g, logic [7:0] pt);
        if (m == 3'd3) return 1'b1;
        if (m == 3'd4) return src ? pt[sel] : g;
        return 1'b0;
    endfunction

    function automatic logic exp_out(logic [2:0] m, logic d);
        return (m == 3'd3 || m == 3'd4) ? d : 1'b0;
    endfunction

    function automatic logic comb_mode(logic [2:0] m);
        return !(m == 3'd1 || m == 3'd2);
    endfunction

    function automatic logic exp_core_comb(logic [2:0] m, logic p);
        return (m == 3'd3) ? 1'b0 : p;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b (mode %0d t=%0t)", req, act, exp, cfg_mode, $time);
        end
    endtask

    task automatic pulse_clk1();
        #2 clk1 = 1'b1;
        #2 clk1 = 1'b0;
        #1;
    endtask

    always @(posedge clk0) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; cfg_mode = 3'd1; cfg_oe_src = 1'b0; cfg_pt_sel = 3'd0;
        cfg_clk_sel = 1'b0; glob_oe = 1'b1; pt_oe = 8'hff; core_out = 1'b1; pad_in = 1'b1;

        // R9: reset clears the register at an edge
        @(posedge clk0); @(negedge clk0); #2;
        check("R9 reg reset", core_in, 1'b0);
        check("R5 reset input mode oe", pad_oe, 1'b0);
        check("R5 reset input mode out", pad_out, 1'b0);
        rst = 1'b0;

        // R2: capture on rising edge, hold between edges
        @(posedge clk0); @(negedge clk0); #2;
        check("R2 capture one", core_in, 1'b1);
        pad_in = 1'b0; #1;
        check("R2 hold between edges", core_in, 1'b1);
        @(posedge clk0); @(negedge clk0); #2;
        check("R2 capture zero", core_in, 1'b0);

        // R4: switch to the second clock; first clock edges are ignored
        cfg_clk_sel = 1'b1; pad_in = 1'b1;
        repeat (3) @(posedge clk0);
        @(negedge clk0); #1;
        check("R4 other clock ignored", core_in, 1'b0);
        pulse_clk1();
        check("R4 selected clock captures", core_in, 1'b1);
        rst = 1'b1; pulse_clk1(); rst = 1'b0;
        check("R9 reset on selected clock", core_in, 1'b0);
        cfg_clk_sel = 1'b0;

        // R3: latch transparent while high, holds while low
        @(negedge clk0); #2;
        cfg_mode = 3'd2; pad_in = 1'b0;
        @(posedge clk0); #1;
        check("R3 transparent low", core_in, 1'b0);
        pad_in = 1'b1; #1;
        check("R3 transparent follows", core_in, 1'b1);
        @(negedge clk0); #2;
        pad_in = 1'b0; #1;
        check("R3 hold while low", core_in, 1'b1);
        rst = 1'b1;
        @(posedge clk0); #1;
        check("R9 latch reset", core_in, 1'b0);
        @(negedge clk0); #2;
        rst = 1'b0;

        // R8: each product-term line in turn
        cfg_mode = 3'd4; cfg_oe_src = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cfg_pt_sel = 3'(i);
            pt_oe = 8'(1 << i); #1;
            check("R8 selected line high", pad_oe, 1'b1);
            pt_oe = ~8'(1 << i); #1;
            check("R8 selected line low", pad_oe, 1'b0);
        end

        // Random mix across all mode codes
        for (int it = 0; it < 400; it++) begin
            logic [2:0] m;
            @(negedge clk0); #2;
            m = 3'($urandom_range(0, 7));
            cfg_mode   = m;
            cfg_oe_src = 1'($urandom);
            cfg_pt_sel = 3'($urandom);
            glob_oe    = 1'($urandom);
            pt_oe      = 8'($urandom);
            core_out   = 1'($urandom);
            pad_in     = 1'($urandom);
            #1;
            check((m == 3'd3) ? "R6 oe" : (m == 3'd4) ? "R7 oe" : "R5 oe", pad_oe,
                  exp_oe(m, cfg_oe_src, cfg_pt_sel, glob_oe, pt_oe));
            check((m == 3'd3) ? "R6 out" : (m == 3'd4) ? "R7 out" : "R5 out", pad_out,
                  exp_out(m, core_out));
            if (comb_mode(m))
                check((m == 3'd3) ? "R6 core_in" : (m == 3'd4) ? "R7 core_in" : "R1 core_in",
                      core_in, exp_core_comb(m, pad_in));
            @(posedge clk0); @(negedge clk0); #1;
            if (!comb_mode(m))
                check((m == 3'd1) ? "R2 random capture" : "R3 random latch", core_in, pad_in);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule